// File: doc/BRIEF.md
# Fused-Body Loop Kernel Engine

This block is a coprocessor for one fixed loop. For every index `i` from 0 up to a programmable trip count it fetches `x` from array A and `y` from array B, reads `D[y]`, and writes `D[y] + x + y + x*y` into `C[x]`. Each array is a word array in one flat byte-addressed space. Element `k` of an array sits at the array's base address plus `4*k`.

The whole loop body is a single unregistered arithmetic operator. The fast clock sequences only the four memory operations of an iteration, and they share one request port in strict program order. Registers that carry state across iterations (the index and the loop decision) move only on a slow step, modelled as an enable that fires in the cycle the store leaves. The host loads the trip count and the four base addresses, pulses `start`, and waits for the one-cycle `done` pulse.

Top module: `loop_fuse_core`

## Requirements
- R1: While reset is held and right after it, `done` and `mem_req` are 0.
- R2: `start` seen while idle with `trip_cnt` = 0 raises `done` in the next cycle, and no memory request is issued.
- R3: Each iteration issues exactly four requests in this order: a read at `base_a+4i`, a read at `base_b+4i`, a read at `base_d+4y`, then a write at `base_c+4x`. `mem_we`=1 marks the write.
- R4: The write data equals `D[y] + x + y + x*y` modulo 2^32. When several iterations hit the same `C[x]`, the last one in program order wins.
- R5: The `D[y]` read is issued only after the `B[i]` response has been captured, and the write only after the `D[y]` response has been captured. Each leaves one cycle with no request, so an iteration's requests appear at cycle offsets 0, 1, 3 and 5.
- R6: `mem_rdata` is taken exactly one cycle after its read request. At most one request is issued per cycle, and `mem_we` is never 1 without `mem_req`.
- R7: The index starts at 0, steps by 1 only in the write cycle, and the loop runs exactly `trip_cnt` iterations of 6 cycles each. Iteration k starts 6k cycles after the cycle that follows the `start` edge.
- R8: `done` is high for exactly one cycle, the cycle right after the last write.
- R9: `start` and `trip_cnt` are ignored while a run is in progress. The trip count is latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| trip_cnt | input | 32 | Number of iterations N |
| base_a | input | 32 | Byte address of A[0] |
| base_b | input | 32 | Byte address of B[0] |
| base_c | input | 32 | Byte address of C[0] |
| base_d | input | 32 | Byte address of D[0] |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |

## Verification
The bench sweeps trip counts from 0 to 8 over several data patterns. It predicts every request's address, kind, data and exact cycle offset, and checks the final contents of C. A wrong captured operand shows up in the write data within the same iteration. A slipped sequencing state moves a request off its expected offset within one to a few cycles. A bad index or trip-count latch shows up as wrong array addresses in the next iteration, or as a `done` pulse at the wrong cycle.

// File: rtl/loop_fuse_core.sv
module loop_fuse_core #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] trip_cnt,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [AW-1:0] base_c,
  input  logic [AW-1:0] base_d,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int WSH = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_LDA, S_LDB, S_CAPB, S_LDD, S_CAPD, S_STC, S_FIN
  } st_t;

  st_t           st;
  logic [DW-1:0] idx, n_q;
  logic [DW-1:0] xv, yv, dv;
  logic [DW-1:0] idx_nxt;
  logic          more;
  logic          step;

  assign idx_nxt   = idx + 1'b1;
  assign more      = idx_nxt < n_q;
  assign step      = (st == S_STC);
  assign mem_wdata = dv + xv + yv + xv * yv;

  assign done    = (st == S_FIN);
  assign mem_req = (st == S_LDA) || (st == S_LDB) || (st == S_LDD) || step;
  assign mem_we  = step;

  always_comb begin
    case (st)
      S_LDA:   mem_addr = base_a + (AW'(idx) << WSH);
      S_LDB:   mem_addr = base_b + (AW'(idx) << WSH);
      S_LDD:   mem_addr = base_d + (AW'(yv) << WSH);
      S_STC:   mem_addr = base_c + (AW'(xv) << WSH);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
      n_q <= '0;
      xv  <= '0;
      yv  <= '0;
      dv  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          n_q <= trip_cnt;
          idx <= '0;
          st  <= (trip_cnt == '0) ? S_FIN : S_LDA;
        end
        S_LDA:  st <= S_LDB;
        S_LDB:  begin xv <= mem_rdata; st <= S_CAPB; end
        S_CAPB: begin yv <= mem_rdata; st <= S_LDD;  end
        S_LDD:  st <= S_CAPD;
        S_CAPD: begin dv <= mem_rdata; st <= S_STC;  end
        S_STC:  begin
          idx <= idx_nxt;
          st  <= more ? S_LDA : S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/loop_fuse_core_chk.sv
module loop_fuse_core_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] trip_cnt,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          busy,
  input logic [DW-1:0] idx
);
  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  assert_zero_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && trip_cnt == '0) |=> (done && !mem_req));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_store_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (!$past(mem_req) && $past(mem_req && !mem_we, 2)));

  assert_we_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx) |-> (($past(mem_req && mem_we) && idx == $past(idx) + 1'b1)
                       || ($past(start) && !$past(busy))));
endmodule

bind loop_fuse_core loop_fuse_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .trip_cnt(trip_cnt),
  .done(done), .mem_req(mem_req), .mem_we(mem_we),
  .busy(st != S_IDLE), .idx(idx)
);

// File: tb/loop_fuse_core_tb.sv
module loop_fuse_core_tb_top;
  localparam logic [31:0] BA = 32'h000, BB = 32'h100, BD = 32'h200, BC = 32'h300;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] trip_cnt = 0;
  logic done, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  loop_fuse_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .trip_cnt(trip_cnt),
    .base_a(BA), .base_b(BB), .base_c(BC), .base_d(BD),
    .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [31:0] mem [256];
  logic [31:0] ia [16], ib [16], id [16], ec [16];
  int checks = 0, fails = 0;
  int edge_cnt = 0, s_edge = 0, acc = 0, run_n = 0;

  always @(posedge clk) begin
    edge_cnt <= edge_cnt + 1;
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    else mem_rdata <= 32'hDEAD_BEEF;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && mem_req) begin
    int it, k, rel, offs;
    logic [31:0] ea, x, y;
    logic ew;
    it = acc / 4; k = acc % 4; rel = edge_cnt - s_edge;
    chk(it < run_n, "R3 request count", acc, 4 * run_n);
    if (it < run_n) begin
      x = ia[it]; y = ib[it];
      case (k)
        0: begin ea = BA + 4 * it; ew = 0; offs = 0; end
        1: begin ea = BB + 4 * it; ew = 0; offs = 1; end
        2: begin ea = BD + 4 * y;  ew = 0; offs = 3; end
        default: begin ea = BC + 4 * x; ew = 1; offs = 5; end
      endcase
      chk(mem_addr == ea, "R3 address", mem_addr, ea);
      chk(mem_we == ew, "R6 write flag", {31'b0, mem_we}, {31'b0, ew});
      chk(rel == 6 * it + offs, "R5/R7 request cycle", rel, 6 * it + offs);
      if (ew) chk(mem_wdata == id[y] + x + y + x * y, "R4 store data",
                  mem_wdata, id[y] + x + y + x * y);
    end
    acc++;
  end

  task automatic run(input int n, input int seed, input bit poke);
    int rel, wd;
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A5A_0000 + i;
    for (int i = 0; i < 16; i++) begin
      ia[i] = (i * 7 + seed) % 16;
      ib[i] = (i * 5 + seed * 3) % 16;
      id[i] = i * 32'h9E37_79B9 + seed * 32'h0101_0101;
      mem[(BA >> 2) + i] = ia[i];
      mem[(BB >> 2) + i] = ib[i];
      mem[(BD >> 2) + i] = id[i];
      ec[i] = mem[(BC >> 2) + i];
    end
    for (int i = 0; i < n; i++) begin
      logic [31:0] x, y;
      x = ia[i]; y = ib[i];
      ec[x] = id[y] + x + y + x * y;
    end
    run_n = n; acc = 0;
    @(negedge clk);
    start = 1; trip_cnt = n; s_edge = edge_cnt + 1;
    @(negedge clk);
    start = 0; trip_cnt = 32'd3;
    wd = 0;
    while (!done && wd < 200) begin
      rel = edge_cnt - s_edge;
      if (poke && rel == 8) begin start = 1; trip_cnt = 1; end
      else if (poke && rel == 9) begin start = 0; trip_cnt = 0; end
      @(negedge clk); wd++;
    end
    start = 0;
    rel = edge_cnt - s_edge;
    chk(done, "R7 run finished", {31'b0, done}, 1);
    chk(rel == 6 * n, "R8 done cycle", rel, 6 * n);
    chk(acc == 4 * n, "R2/R9 access total", acc, 4 * n);
    @(negedge clk);
    chk(!done, "R8 done one cycle", {31'b0, done}, 0);
    for (int i = 0; i < 16; i++)
      chk(mem[(BC >> 2) + i] == ec[i], "R4 C contents", mem[(BC >> 2) + i], ec[i]);
    repeat (2) @(negedge clk);
    chk(!done && !mem_req, "R9 idle after run", {30'b0, done, mem_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !mem_req, "R1 reset outputs", {30'b0, done, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !mem_req, "R1 after reset", {30'b0, done, mem_req}, 0);
    for (int n = 0; n <= 8; n++) run(n, n + 1, 0);
    run(0, 11, 0);
    run(12, 5, 0);
    run(5, 9, 1);
    run(16, 13, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule